// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Model

This block is a synthesizable behavioural model of a static memory that moves four data words per access, one word on every edge of a complementary clock pair. Inside the model a single double-rate clock stands for that pair. Successive rising edges alternate between the primary phase (called the K edge here) and the complementary phase (the K-bar edge). An output flag tells the surrounding logic which phase the next edge belongs to.

A request is sampled on a K edge when the load strobe is low. The read/write select then picks the direction. The address holds a row in its upper bits and a two-bit start offset in its lowest bits. All four words of one row are kept together as a single wide entry. The start offset only rotates the order in which the words are moved, wrapping within the row. Writes use active-low enables, one for each 9-bit lane and sampled with each word. Read data is driven through a registered output with a separate drive-enable in place of a bidirectional pin. Requests may arrive at most once every two primary cycles, so a read placed in the slot straight after a write sees the new data. A request that comes too early is dropped and flagged.

Top module: `ddr_b4_sram`

## Requirements
- R1: A request is accepted on a K edge when `ld_n` is 0. `rw`=1 selects a read and `rw`=0 a write. With `ld_n`=1 nothing starts and `rw` has no effect.
- R2: The first rising edge after reset release is a K edge, and edges then alternate K, K-bar. `k_edge` is 1 exactly in the cycles whose next rising edge is a K edge. A low `ld_n` on a K-bar edge is ignored.
- R3: A request on the K edge two edges after an accepted request is dropped: no data moves and memory is unchanged. `proto_err` is 1 for exactly the one cycle after that edge. A dropped request does not block the K edge after it.
- R4: For a write accepted on edge e, burst words 0 to 3 are taken from `d_in` on edges e+2, e+3, e+4 and e+5, so words 0 and 2 fall on K edges.
- R5: `bw_n` bit i enables lane i, which is bits 9i+8 down to 9i of a word. It is active low and sampled with its word. A lane whose bit is 1 keeps its stored contents.
- R6: For a read accepted on edge e, `q_out` holds burst words 0 to 3 after edges e+3, e+4, e+5 and e+6. `q_oe` is 1 in exactly those cycles and 0 in every other cycle.
- R7: With `addr` = {row, s}, burst word i goes to or comes from word position (s+i) mod 4 of that row. The row part is never incremented.
- R8: A read accepted four edges after a write to the same row returns the data that write stored.
- R9: During and straight after reset, `q_oe` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; rising edges alternate K and K-bar |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_edge | output | 1 | 1 when the next rising edge is a K edge |
| ld_n | input | 1 | Active-low request strobe, sampled on K edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | {row, two-bit start offset} |
| bw_n | input | DW/LW | Active-low lane write enables, one per 9-bit lane |
| d_in | input | DW | Write data, one word per edge |
| q_out | output | DW | Registered read data |
| q_oe | output | 1 | Drive enable for `q_out` |
| proto_err | output | 1 | One-cycle flag for a dropped early request |

## Verification
Each result falls on a fixed edge counted from the accepting K edge. Write words are consumed on edges +2 to +5, read words appear after edges +3 to +6, and the error flag appears after the offending edge. The bench places every stimulus and expectation on an absolute edge number. Its scoreboard pairs each read word with the edge it is due on. A monitor samples on the falling clock, so it sees what the previous rising edge produced. Every edge without an expected word must show a quiet bus and a low error flag, which catches both late and extra data.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  // Word position inside a row for burst beat `beat` when the burst starts
  // at offset `start`: linear order, wrapping modulo four.
  function automatic logic [1:0] burst_slot(input logic [1:0] start, input logic [1:0] beat);
    return start + beat;
  endfunction

  // Bit position of lane `lane` of word position `slot` inside a wide row.
  function automatic int lane_lsb(input int slot, input int lane, input int dw, input int lw);
    return slot * dw + lane * lw;
  endfunction

endpackage

// File: rtl/ddrb4_ctrl.sv
module ddrb4_ctrl
  import ddrb4_pkg::*;
#(
  parameter int AW      = 6,
  parameter int WR_LEAD = 2,
  parameter int RD_LEAD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_n,
  input  logic          rw,
  input  logic [AW-1:0] addr,
  output logic          kph,
  output logic          accept,
  output logic          reject,
  output logic          wr_start,
  output logic [AW-1:0] wr_addr,
  output logic          rd_start,
  output logic [AW-1:0] rd_addr,
  output logic          proto_err
);
  localparam int STAGES  = (RD_LEAD > WR_LEAD) ? RD_LEAD : WR_LEAD;
  localparam int WR_IDX  = WR_LEAD - 1;
  localparam int RD_IDX  = RD_LEAD - 1;
  localparam int SLOT_GAP = 1;  // stage holding the request of the previous K edge

  logic [STAGES-1:0] stg_vld;
  logic [STAGES-1:0] stg_rd;
  logic [AW-1:0]     stg_addr [STAGES];

  logic req_seen;
  assign req_seen = kph & ~ld_n;
  assign accept   = req_seen & ~stg_vld[SLOT_GAP];
  assign reject   = req_seen &  stg_vld[SLOT_GAP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kph       <= 1'b1;
      stg_vld   <= '0;
      stg_rd    <= '0;
      proto_err <= 1'b0;
      for (int i = 0; i < STAGES; i++) stg_addr[i] <= '0;
    end else begin
      kph       <= ~kph;
      stg_vld   <= {stg_vld[STAGES-2:0], accept};
      stg_rd    <= {stg_rd[STAGES-2:0], rw};
      proto_err <= reject;
      stg_addr[0] <= addr;
      for (int i = 1; i < STAGES; i++) stg_addr[i] <= stg_addr[i-1];
    end
  end

  assign wr_start = stg_vld[WR_IDX] & (stg_rd[WR_IDX] == OP_WRITE);
  assign wr_addr  = stg_addr[WR_IDX];
  assign rd_start = stg_vld[RD_IDX] & (stg_rd[RD_IDX] == OP_READ);
  assign rd_addr  = stg_addr[RD_IDX];

endmodule

// File: rtl/ddrb4_seq.sv
module ddrb4_seq
  import ddrb4_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          active,
  output logic [AW-3:0] row,
  output logic [1:0]    slot
);
  localparam logic [1:0] LAST_BEAT = 2'd3;

  logic          run;
  logic [1:0]    beat_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    beat;
  logic [AW-1:0] cur;

  assign active = start | run;
  assign beat   = start ? 2'd0 : beat_q;
  assign cur    = start ? start_addr : addr_q;
  assign row    = cur[AW-1:2];
  assign slot   = burst_slot(cur[1:0], beat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      beat_q <= '0;
      addr_q <= '0;
    end else if (start) begin
      run    <= 1'b1;
      beat_q <= 2'd1;
      addr_q <= start_addr;
    end else if (run) begin
      beat_q <= beat_q + 2'd1;
      if (beat_q == LAST_BEAT) run <= 1'b0;
    end
  end

endmodule

// File: rtl/ddrb4_array.sv
module ddrb4_array
  import ddrb4_pkg::*;
#(
  parameter int DW  = 36,
  parameter int LW  = 9,
  parameter int RAW = 4
) (
  input  logic                clk,
  input  logic                we,
  input  logic [RAW-1:0]      wrow,
  input  logic [1:0]          wslot,
  input  logic [DW/LW-1:0]    wlane_n,
  input  logic [DW-1:0]       wdata,
  input  logic [RAW-1:0]      rrow,
  input  logic [1:0]          rslot,
  output logic [DW-1:0]       rdata
);
  localparam int LANES = DW / LW;
  localparam int ROWS  = 2 ** RAW;
  localparam int EW    = 4 * DW;

  logic [EW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (!wlane_n[l])
          mem[wrow][lane_lsb(int'(wslot), l, DW, LW) +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  assign rdata = mem[rrow][lane_lsb(int'(rslot), 0, DW, LW) +: DW];

endmodule

// File: rtl/ddr_b4_sram.sv
module ddr_b4_sram
  import ddrb4_pkg::*;
#(
  parameter int DW = 36,
  parameter int LW = 9,
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                k_edge,
  input  logic                ld_n,
  input  logic                rw,
  input  logic [AW-1:0]       addr,
  input  logic [DW/LW-1:0]    bw_n,
  input  logic [DW-1:0]       d_in,
  output logic [DW-1:0]       q_out,
  output logic                q_oe,
  output logic                proto_err
);
  localparam int RAW = AW - 2;

  // Named internal events, observed by the bound checker.
  logic          kph;
  logic          acc_evt;
  logic          rej_evt;
  logic          wr_start;
  logic          rd_start;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          wr_act;
  logic          rd_act;
  logic [RAW-1:0] wrow;
  logic [RAW-1:0] rrow;
  logic [1:0]    wslot;
  logic [1:0]    rslot;
  logic [DW-1:0] rdata;
  logic [DW-1:0] q_reg;

  ddrb4_ctrl #(.AW(AW), .WR_LEAD(2), .RD_LEAD(3)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .rw        (rw),
    .addr      (addr),
    .kph       (kph),
    .accept    (acc_evt),
    .reject    (rej_evt),
    .wr_start  (wr_start),
    .wr_addr   (wr_addr),
    .rd_start  (rd_start),
    .rd_addr   (rd_addr),
    .proto_err (proto_err)
  );

  ddrb4_seq #(.AW(AW)) u_wseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (wr_start),
    .start_addr (wr_addr),
    .active     (wr_act),
    .row        (wrow),
    .slot       (wslot)
  );

  ddrb4_seq #(.AW(AW)) u_rseq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (rd_start),
    .start_addr (rd_addr),
    .active     (rd_act),
    .row        (rrow),
    .slot       (rslot)
  );

  ddrb4_array #(.DW(DW), .LW(LW), .RAW(RAW)) u_arr (
    .clk     (clk),
    .we      (wr_act),
    .wrow    (wrow),
    .wslot   (wslot),
    .wlane_n (bw_n),
    .wdata   (d_in),
    .rrow    (rrow),
    .rslot   (rslot),
    .rdata   (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg <= '0;
      q_oe  <= 1'b0;
    end else begin
      q_oe  <= rd_act;
      q_reg <= rd_act ? rdata : '0;
    end
  end

  assign q_out  = q_reg;
  assign k_edge = kph;

endmodule

// File: rtl/ddr_b4_sram_chk.sv
module ddr_b4_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic ld_n,
  input logic k_edge,
  input logic acc_evt,
  input logic rej_evt,
  input logic rd_act,
  input logic q_oe,
  input logic proto_err
);
  // Edges since the last accepted request, saturating at 3.
  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= 2'd3;
    else if (acc_evt)        since <= 2'd0;
    else if (since != 2'd3)  since <= since + 2'd1;
  end

  p_accept_on_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |-> k_edge);

  p_ld_high_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |-> (!acc_evt && !rej_evt));

  p_slot_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |-> (since >= 2'd2));

  p_err_after_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rej_evt |=> proto_err);

  p_err_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(rej_evt));

  p_oe_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    q_oe |-> $past(rd_act));

endmodule

bind ddr_b4_sram ddr_b4_sram_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_n      (ld_n),
  .k_edge    (k_edge),
  .acc_evt   (acc_evt),
  .rej_evt   (rej_evt),
  .rd_act    (rd_act),
  .q_oe      (q_oe),
  .proto_err (proto_err)
);

// File: tb/ddr_b4_sram_tb.sv
`timescale 1ns/1ps
module ddr_b4_sram_tb;
  localparam int DW = 36, LW = 9, AW = 6, LANES = 4, ROWS = 16;
  localparam int END_EDGE = 100;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             k_edge;
  logic             ld_n = 1'b1;
  logic             rw = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [LANES-1:0] bw_n = '1;
  logic [DW-1:0]    d_in = '0;
  logic [DW-1:0]    q_out;
  logic             q_oe;
  logic             proto_err;

  ddr_b4_sram #(.DW(DW), .LW(LW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .ld_n(ld_n), .rw(rw),
    .addr(addr), .bw_n(bw_n), .d_in(d_in), .q_out(q_out), .q_oe(q_oe),
    .proto_err(proto_err)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int ecnt = 0;       // rising edges since reset release = index of next edge
  bit done = 1'b0;

  // Edge-indexed stimulus schedule
  bit               s_ld [int];
  bit               s_rw [int];
  logic [AW-1:0]    s_ad [int];
  logic [DW-1:0]    s_d  [int];
  logic [LANES-1:0] s_m  [int];

  typedef struct {
    int          e;
    logic [DW-1:0] d;
    int          tag;
  } exp_t;
  exp_t rdq[$];
  int   errq[$];
  logic [DW-1:0] ref_mem [ROWS][4];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, ecnt - 1);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return {4'(seed + i), 32'(seed * 32'h9E3779B1) ^ 32'(i * 32'h7F4A7C15)};
  endfunction

  // kind: 0 accepted, 1 dropped with error, 2 ignored silently
  task automatic issue(input int e, input bit rd, input int row, input int off,
                       input int kind, input int seed, input logic [4*LANES-1:0] msk,
                       input int tag);
    s_ld[e] = 1'b1;
    s_rw[e] = rd;
    s_ad[e] = AW'(row * 4 + off);
    if (kind == 1) errq.push_back(e);
    if (kind == 0 && !rd) begin
      for (int i = 0; i < 4; i++) begin
        logic [DW-1:0] w;
        int slot;
        w = pat(seed, i);
        slot = (off + i) % 4;
        s_d[e + 2 + i] = w;
        s_m[e + 2 + i] = msk[i*LANES +: LANES];
        for (int l = 0; l < LANES; l++)
          if (!msk[i*LANES + l]) ref_mem[row][slot][l*LW +: LW] = w[l*LW +: LW];
      end
    end
    if (kind == 0 && rd) begin
      for (int i = 0; i < 4; i++)
        rdq.push_back('{e + 3 + i, ref_mem[row][(off + i) % 4], tag});
    end
  endtask

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  // Driver: applies the inputs for the coming edge ecnt
  always @(negedge clk) begin
    ld_n = s_ld.exists(ecnt) ? 1'b0 : 1'b1;
    rw   = s_rw.exists(ecnt) ? s_rw[ecnt] : ecnt[0];  // R1: rw toggles while idle
    addr = s_ad.exists(ecnt) ? s_ad[ecnt] : AW'(ecnt);
    d_in = s_d.exists(ecnt)  ? s_d[ecnt]  : '0;
    bw_n = s_m.exists(ecnt)  ? s_m[ecnt]  : '1;
  end

  // Monitor: compares what the previous edge produced
  always @(negedge clk) begin
    int last;
    if (rst_n && ecnt > 0 && !done) begin
      last = ecnt - 1;
      if (rdq.size() > 0 && rdq[0].e == last) begin
        exp_t x;
        x = rdq.pop_front();
        check(q_oe === 1'b1, $sformatf("R6 R%0d drive", x.tag), DW'(q_oe), DW'(1));
        check(q_out === x.d, $sformatf("R%0d data", x.tag), q_out, x.d);
      end else begin
        check(q_oe === 1'b0, "R1 R2 R3 R6 idle bus", DW'(q_oe), DW'(0));
      end
      if (errq.size() > 0 && errq[0] == last) begin
        void'(errq.pop_front());
        check(proto_err === 1'b1, "R3 error flag", DW'(proto_err), DW'(1));
      end else begin
        check(proto_err === 1'b0, "R3 error quiet", DW'(proto_err), DW'(0));
      end
      check(k_edge === (ecnt % 2 == 0), "R2 phase", DW'(k_edge), DW'(ecnt % 2 == 0));
    end
  end

  initial begin
    // R4 R8: write row 1 from offset 0, read it in the very next slot
    issue(4,  1'b0, 1, 0, 0, 1, 16'h0000, 4);
    issue(8,  1'b1, 1, 0, 0, 0, 16'h0000, 8);
    // R7: the three other start offsets on reads
    issue(12, 1'b1, 1, 1, 0, 0, 16'h0000, 7);
    issue(16, 1'b1, 1, 2, 0, 0, 16'h0000, 7);
    issue(20, 1'b1, 1, 3, 0, 0, 16'h0000, 7);
    // R7: wrapped write order, read back from offset 0
    issue(24, 1'b0, 2, 2, 0, 2, 16'h0000, 7);
    issue(28, 1'b1, 2, 0, 0, 0, 16'h0000, 7);
    // R5: partial lane masks (word0 lane0 only, word1 lanes1,3, word2 none, word3 all)
    issue(32, 1'b0, 1, 0, 0, 3, {4'b0000, 4'b1111, 4'b0101, 4'b1110}, 5);
    issue(36, 1'b1, 1, 0, 0, 0, 16'h0000, 5);
    // R3: early write dropped, memory keeps the first write
    issue(40, 1'b0, 3, 0, 0, 4, 16'h0000, 3);
    issue(42, 1'b0, 3, 1, 1, 5, 16'h0000, 3);
    issue(44, 1'b1, 3, 0, 0, 0, 16'h0000, 3);
    // R3: early read dropped, no extra output
    issue(48, 1'b1, 3, 2, 0, 0, 16'h0000, 3);
    issue(50, 1'b1, 1, 0, 1, 0, 16'h0000, 3);
    // R2: load strobe on a K-bar edge is ignored
    issue(57, 1'b1, 2, 0, 2, 0, 16'h0000, 2);
    // R5: fully masked write changes nothing
    issue(60, 1'b0, 1, 0, 0, 6, 16'hFFFF, 5);
    issue(64, 1'b1, 1, 0, 0, 0, 16'h0000, 5);
    // R8 R7: read, write, then forwarded read at offset 3
    issue(68, 1'b1, 2, 1, 0, 0, 16'h0000, 7);
    issue(72, 1'b0, 2, 1, 0, 7, 16'h0000, 8);
    issue(76, 1'b1, 2, 3, 0, 0, 16'h0000, 8);

    repeat (3) @(negedge clk);
    // R9: reset state
    check(q_oe === 1'b0, "R9 drive in reset", DW'(q_oe), DW'(0));
    check(proto_err === 1'b0, "R9 error in reset", DW'(proto_err), DW'(0));
    check(k_edge === 1'b1, "R9 R2 phase in reset", DW'(k_edge), DW'(1));
    rst_n = 1'b1;
    while (ecnt < END_EDGE) @(negedge clk);
    done = 1'b1;
    check(rdq.size() == 0, "R6 pending reads", DW'(rdq.size()), DW'(0));
    check(errq.size() == 0, "R3 pending errors", DW'(errq.size()), DW'(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule